// File: doc/BRIEF.md
# Digital Crystal Trim Adjuster

This block turns a stream of oscillator count enables into a one-pulse-per-second tick and corrects the crystal's frequency error in the digital domain. A down-counting prescaler normally spans `DIV` enabled counts. On selected seconds it is reloaded with a longer or shorter span, so the mean tick rate moves by a programmed number of parts per billion. The analog oscillator and any calendar that consumes the tick are outside the block.

An 8-bit trim word sets the correction. Bits 5:0 hold an offset-coded count field and bit 6 selects shortening instead of lengthening. Bit 7 selects fine resolution: the correction is applied once a minute rather than three times a minute, so one step is worth a third as much. If bits 5:1 are all zero, nothing is corrected. Each step is `STEP_CNT` oscillator counts. With the default 32768 division and 2 counts per step, one step is about 3051 ppb in coarse mode and about 1017 ppb in fine mode. The legal range is 62 steps in either direction.

Seconds are indexed from reset. The second that begins when reset is released has index 0. Each tick starts the next index, counted modulo `SEC_PER_MIN`. The current prescaler count is brought out so the phase within the second can be observed.

Top module: `trim_adjuster`

## Requirements
- R1: While reset is asserted and directly after it is released, `presc_state` equals DIV-1 and `tick_1hz` is low. The second that begins at reset release has index 0 and is never lengthened or shortened.
- R2: `presc_state` falls by one on each enabled count. On the enabled count where it is 0, it reloads with the length of the next second minus one. `tick_1hz` is high for exactly the one clock cycle after that count. A second that is not corrected lasts DIV enabled counts.
- R3: If trim bits 5:1 are all zero, every second lasts DIV counts, whatever bits 0 and 6 hold.
- R4: With bit 6 clear and bits 5:1 not all zero, a corrected second lasts DIV + STEP_CNT*(field-1) counts, where field is bits 5:0.
- R5: With bit 6 set and bits 5:1 not all zero, a corrected second lasts DIV - STEP_CNT*((~field & 63)+1) counts.
- R6: With bit 7 clear, correction applies to seconds whose index is a multiple of COARSE_SEC (0, 20 and 40 by default). With bit 7 set, it applies only to index 0. All other seconds last DIV counts.
- R7: The extreme codes 0x3F and 0x42 (bits 6:0) give +62 and -62 steps, that is DIV+124 and DIV-124 counts by default. `presc_state` never exceeds DIV-1+62*STEP_CNT.
- R8: While `osc_en` is low, `presc_state` holds its value and no tick is produced.
- R9: The trim word is sampled on the enabled count that ends the previous second. Changing it in the middle of a second does not alter the length of that second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One oscillator count per cycle in which it is high |
| trim_reg | input | 8 | Trim word: bit 7 fine mode, bit 6 shorten, bits 5:0 offset-coded count |
| tick_1hz | output | 1 | One-cycle pulse at the start of each second |
| presc_state | output | CW = clog2(DIV+62*STEP_CNT) | Counts remaining in the current second |

## Verification
The assertions assume that `osc_en` and `trim_reg` are stable across each rising clock edge and take legal values there. They also assume the trim word can change at any cycle, because sampling happens only at a wrap. The stimulus drives every input one nanosecond after the falling edge, changes the trim word both at second boundaries and in the middle of a corrected second, and sends gapped `osc_en` patterns, so every input stays inside those assumptions. A behavioural reference tracks the enabled counts and the second index from the requirements, and it checks the tick and the prescaler value on every cycle.

// File: rtl/trim_adj_pkg.sv
package trim_adj_pkg;
   localparam int FIELD_W   = 6;
   localparam int MAX_STEPS = 62;

   typedef struct packed {
      logic                fine;
      logic                shorten;
      logic [FIELD_W-1:0]  field;
   } trim_word_t;
endpackage

// File: rtl/trim_step_decode.sv
module trim_step_decode
   import trim_adj_pkg::*;
#(
   parameter int STEP_CNT = 2,
   parameter int CW       = 16
) (
   input  trim_word_t     trim_i,
   output logic [CW-1:0]  adj_o
);
   logic          dead;
   logic [6:0]    steps;
   logic [CW-1:0] scaled;

   always_comb begin
      dead  = (trim_i.field[FIELD_W-1:1] == '0);
      steps = trim_i.shorten ? ({1'b0, ~trim_i.field} + 7'd1)
                             : ({1'b0,  trim_i.field} - 7'd1);
   end

   generate
      if ((STEP_CNT & (STEP_CNT - 1)) == 0) begin : g_shift
         assign scaled = CW'(steps) << $clog2(STEP_CNT);
      end else begin : g_mul
         assign scaled = CW'(steps) * CW'(STEP_CNT);
      end
   endgenerate

   always_comb begin
      if (dead)
         adj_o = '0;
      else if (trim_i.shorten)
         adj_o = '0 - scaled;
      else
         adj_o = scaled;
   end

   // R7: the encoding never yields more than 62 steps outside the dead zone
   always_comb begin
      if (!dead)
         assert_step_limit_R7: assert (steps <= 7'(MAX_STEPS));
   end
endmodule

// File: rtl/trim_slot_seq.sv
module trim_slot_seq #(
   parameter int SEC_PER_MIN = 60,
   parameter int COARSE_SEC  = 20,
   parameter int SW          = $clog2(SEC_PER_MIN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   input  logic fine_i,
   output logic slot_nx_o
);
   logic [SW-1:0] sec_q;
   logic [SW-1:0] sec_nx;

   always_comb begin
      sec_nx = (sec_q == SW'(SEC_PER_MIN - 1)) ? '0 : sec_q + 1'b1;
      if (fine_i)
         slot_nx_o = (sec_nx == '0);
      else
         slot_nx_o = ((int'(sec_nx) % COARSE_SEC) == 0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sec_q <= '0;
      else if (adv_i)
         sec_q <= sec_nx;
   end

   assert_sec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sec_q) < SEC_PER_MIN);

   assert_sec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(sec_q));
endmodule

// File: rtl/trim_presc.sv
module trim_presc #(
   parameter int            CW      = 16,
   parameter logic [CW-1:0] RST_VAL = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic [CW-1:0] load_i,
   output logic [CW-1:0] cnt_o,
   output logic          wrap_o
);
   assign wrap_o = en_i && (cnt_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= RST_VAL;
      else if (en_i)
         cnt_o <= (cnt_o == '0) ? load_i : cnt_o - 1'b1;
   end

   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(cnt_o));
endmodule

// File: rtl/trim_adjuster.sv
module trim_adjuster
   import trim_adj_pkg::*;
#(
   parameter int DIV         = 32768,
   parameter int STEP_CNT    = 2,
   parameter int SEC_PER_MIN = 60,
   parameter int COARSE_SEC  = 20,
   parameter int CW          = $clog2(DIV + MAX_STEPS * STEP_CNT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          osc_en,
   input  logic [7:0]    trim_reg,
   output logic          tick_1hz,
   output logic [CW-1:0] presc_state
);
   localparam logic [CW-1:0] BASE    = CW'(DIV - 1);
   localparam int            MAX_LEN = DIV - 1 + MAX_STEPS * STEP_CNT;

   generate
      if (DIV <= MAX_STEPS * STEP_CNT) begin : g_bad_div
         $error("DIV must exceed the largest shortening");
      end
      if ((SEC_PER_MIN % COARSE_SEC) != 0) begin : g_bad_interval
         $error("COARSE_SEC must divide SEC_PER_MIN");
      end
      if (CW < 8) begin : g_bad_width
         $error("prescaler width too small");
      end
   endgenerate

   trim_word_t    tw;
   logic [CW-1:0] adj;
   logic          slot_nx;
   logic          wrap;
   logic [CW-1:0] load_val;

   assign tw       = trim_word_t'(trim_reg);
   assign load_val = slot_nx ? BASE + adj : BASE;

   trim_step_decode #(.STEP_CNT(STEP_CNT), .CW(CW)) u_decode (
      .trim_i (tw),
      .adj_o  (adj)
   );

   trim_slot_seq #(.SEC_PER_MIN(SEC_PER_MIN), .COARSE_SEC(COARSE_SEC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (wrap),
      .fine_i    (tw.fine),
      .slot_nx_o (slot_nx)
   );

   trim_presc #(.CW(CW), .RST_VAL(BASE)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (osc_en),
      .load_i (load_val),
      .cnt_o  (presc_state),
      .wrap_o (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick_1hz <= 1'b0;
      else
         tick_1hz <= wrap;
   end

   assert_presc_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(presc_state) <= MAX_LEN);

   assert_tick_after_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick_1hz) |-> ($past(presc_state) == '0));

   assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_1hz |=> !tick_1hz || int'(presc_state) < MAX_LEN);
endmodule

// File: tb/tb_trim_adjuster.sv
module tb_trim_adjuster;
   localparam int DIV  = 256;
   localparam int STEP = 2;
   localparam int CW   = $clog2(DIV + 62 * STEP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          osc_en = 1'b0;
   logic [7:0]    trim_reg = 8'h00;
   logic          tick_1hz;
   logic [CW-1:0] presc_state;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   // behavioural reference state
   int         d_cnt = 0;
   int         exp_len = DIV;
   int         bsec = 0;
   logic [7:0] start_trim = 8'h00;
   string      cur_tag = "R1";

   always #2.5 clk = ~clk;

   trim_adjuster #(.DIV(DIV), .STEP_CNT(STEP)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .osc_en      (osc_en),
      .trim_reg    (trim_reg),
      .tick_1hz    (tick_1hz),
      .presc_state (presc_state)
   );

   function automatic int len_of(int s, logic [7:0] t);
      int f;
      bit slot;
      slot = t[7] ? (s == 0) : (s % 20 == 0);
      f = int'(t[5:0]);
      if (!slot || (f >> 1) == 0) return DIV;
      if (t[6]) return DIV - STEP * (63 - f + 1);
      return DIV + STEP * (f - 1);
   endfunction

   function automatic string tag_of(int s, logic [7:0] t);
      int f;
      bit slot;
      slot = t[7] ? (s == 0) : (s % 20 == 0);
      f = int'(t[5:0]);
      if (!slot && t[7] && (s % 20 == 0)) return "R6";
      if (!slot) return "R2";
      if ((f >> 1) == 0) return "R3";
      if (t[6:0] == 7'h3F || t[6:0] == 7'h42) return "R7";
      if (t[7]) return "R6";
      if (t[6]) return "R5";
      return "R4";
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d sec=%0d", tag, what, act, expv, bsec);
      end
   endtask

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         bit exp_tick;
         cycles++;
         if (osc_en) d_cnt++;
         if (trim_reg != start_trim) cur_tag = "R9";
         exp_tick = (d_cnt == exp_len);
         check(tick_1hz == exp_tick, osc_en ? cur_tag : "R8", "tick", int'(tick_1hz), int'(exp_tick));
         if (exp_tick) begin
            bsec       = (bsec + 1) % 60;
            exp_len    = len_of(bsec, trim_reg);
            cur_tag    = tag_of(bsec, trim_reg);
            start_trim = trim_reg;
            d_cnt      = 0;
         end
         check(int'(presc_state) == exp_len - 1 - d_cnt, osc_en ? cur_tag : "R8",
               "presc_state", int'(presc_state), exp_len - 1 - d_cnt);
      end
   end

   task automatic wait_ticks(int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (!tick_1hz);
      end
      #1;
   endtask

   task automatic gated_ticks(int n);
      int seen = 0;
      int k = 0;
      while (seen < n) begin
         @(negedge clk);
         if (tick_1hz) seen++;
         #1;
         osc_en = (k % 3 != 0);
         k++;
      end
      osc_en = 1'b1;
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(int'(presc_state) == DIV - 1, "R1", "reset presc", int'(presc_state), DIV - 1);
      check(tick_1hz == 1'b0, "R1", "reset tick", int'(tick_1hz), 0);
      #1;
      rst_n  = 1'b1;
      osc_en = 1'b1;
      @(negedge clk);
      check(int'(presc_state) == DIV - 2, "R1", "first count", int'(presc_state), DIV - 2);
      #1;
      wait_ticks(20);               // slot 20 untrimmed
      trim_reg = 8'h01; wait_ticks(20);   // R3 dead zone
      trim_reg = 8'h40; wait_ticks(20);   // R3
      trim_reg = 8'h41; wait_ticks(20);   // R3
      trim_reg = 8'h05; wait_ticks(20);   // R4 +4 steps
      trim_reg = 8'h3F; wait_ticks(20);   // R7 +62 steps
      trim_reg = 8'h7E; wait_ticks(20);   // R5 -2 steps
      trim_reg = 8'h42; wait_ticks(20);   // R7 -62 steps
      trim_reg = 8'h85; wait_ticks(60);   // R6 fine, +4 steps at index 0 only
      trim_reg = 8'hC2; wait_ticks(60);   // R6 fine, -62 steps
      trim_reg = 8'h10; gated_ticks(20);  // R8 gapped counts
      trim_reg = 8'h05;
      while (bsec % 20 != 0) wait_ticks(1);
      repeat (40) @(negedge clk);
      #1;
      trim_reg = 8'h3F;                   // R9 mid-second change
      wait_ticks(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule